// File: doc/BRIEF.md
# Low-Power Stop Mode Controller

This block moves a microcontroller core between normal run, a deep stop state and a light stop state. A stop-instruction strobe, together with a requested depth, selects the stop state. From the current state the block derives the system clock enable, the debug clock enable, the regulator standby request, the I/O high-impedance control and the pin-hold control. Any interrupt line or the periodic-timer tick wakes the core again. A synchronous reset always returns it to run.

An attached background debug port can override the stop behaviour through a debug-enable bit. Software cannot reach this bit from the memory map. It is written only by a debug write-control command and read only by a debug read-status command. While the bit is set:

- a deep stop request is turned into a light stop that keeps the clocks running and the regulator at full regulation;
- debug memory-access commands issued during stop are refused with an error;
- a debug halt command can pull the core from stop, or from run, into active debug mode. A resume command ends active debug mode.

Top module: `stop_mode_ctrl`

## Requirements
- R1: After reset the mode output is run (0), the debug-enable bit reads 0, the system and debug clock enables are 1, and regulator standby, high-impedance, hold, exit-reset and the timer flag are all 0.
- R2: With debug disabled, a stop strobe enters, on the next cycle, deep stop (mode 2) when stop_deep is 1 and light stop (mode 1) when it is 0. Deep stop gives both clock enables 0, standby 1, high-impedance 1 and hold 0. Light stop gives both clock enables 0, standby 1, high-impedance 0 and hold 1.
- R3: With debug enabled, a stop strobe of either depth enters light stop (mode 1). Both clock enables stay 1 and standby stays 0.
- R4: A debug memory-access command gets a response on the next cycle. While stopped (mode 1 or 2) the response has valid 1, error 1 and access 0. In run or debug mode it has valid 1, error 0 and access 1.
- R5: A debug halt command enters debug mode (mode 3) on the next cycle from run or from light stop, but only when debug is enabled. When debug is disabled the mode is left unchanged.
- R6: A write-control command loads dbg_wr_val into the debug-enable bit. A read-status command returns, one cycle later with valid high, bit 0 = debug-enable and bit 1 = stopped (mode 1 or 2).
- R7: A timer tick sets the timer flag on the next cycle when the mode is not deep stop. In deep stop a tick still wakes the core but leaves the flag clear. The ack input clears the flag, and a tick in the same cycle as the ack wins.
- R8: An interrupt on any line, or a tick, in light stop gives one cycle that still reports mode 1 with the system clock enable already 1. On the cycle after that the mode is run.
- R9: An interrupt or a tick in deep stop gives one cycle that reports mode 2 with exit_rst 1, high-impedance 1 and both clock enables 1. On the cycle after that the mode is run with exit_rst 0.
- R10: In debug mode, stop strobes and interrupts are ignored and memory commands are served normally. A resume command returns to run on the next cycle.
- R11: While the debug clock enable is 0, all debug commands are ignored: the debug-enable bit does not change and no response appears.
- R12: A reset in any mode, including deep stop, returns to run with the debug-enable bit cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_exec | input | 1 | Stop instruction strobe |
| stop_deep | input | 1 | Requested depth: 1 deep, 0 light |
| irq | input | IRQ_W | Interrupt request lines |
| tmr_tick | input | 1 | Periodic timer tick |
| tmr_ack | input | 1 | Clears the timer flag |
| dbg_wr_ctl | input | 1 | Debug write-control command |
| dbg_wr_val | input | 1 | Debug-enable value to write |
| dbg_rd_stat | input | 1 | Debug read-status command |
| dbg_mem_cmd | input | 1 | Debug memory-access-with-status command |
| dbg_halt | input | 1 | Debug halt (enter debug mode) command |
| dbg_resume | input | 1 | Debug resume command |
| mode | output | 2 | 0 run, 1 light stop, 2 deep stop, 3 debug |
| sys_clk_en | output | 1 | System clock enable |
| dbg_clk_en | output | 1 | Debug logic clock enable |
| reg_stby | output | 1 | Regulator standby request |
| io_hiz | output | 1 | Drive pins high-impedance |
| io_hold | output | 1 | Hold pin states |
| exit_rst | output | 1 | Reset-style exit pulse from deep stop |
| tmr_flag | output | 1 | Periodic timer flag |
| dbg_rd_valid | output | 1 | Read-status response valid |
| dbg_rd_data | output | 2 | {stopped, debug-enable} |
| dbg_mem_valid | output | 1 | Memory command response valid |
| dbg_mem_err | output | 1 | Memory command refused (stopped) |
| dbg_mem_do | output | 1 | Memory access performed |

## Verification
The bench builds the block with IRQ_W = 3, which is small enough to sweep every interrupt line as a wake source from each stop depth. It also sweeps the four combinations of debug-enable and requested depth through entry and exit. At that size, every mode can be paired with every debug command, which exposes the gating by the debug clock and the refusal of memory access during stop.

// File: rtl/stopctl_pkg.sv
package stopctl_pkg;

    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_LIGHT  = 3'd1,
        ST_DEEP   = 3'd2,
        ST_WAKE_L = 3'd3,
        ST_WAKE_D = 3'd4,
        ST_DEBUG  = 3'd5
    } state_e;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_LIGHT = 2'd1,
        MODE_DEEP  = 2'd2,
        MODE_DEBUG = 2'd3
    } mode_e;

    typedef struct packed {
        logic  sys_clk_en;
        logic  dbg_clk_en;
        logic  reg_stby;
        logic  io_hiz;
        logic  io_hold;
        logic  exit_rst;
        mode_e mode;
    } ctl_out_t;

    function automatic ctl_out_t decode_state(input state_e s, input logic dbg_en);
        ctl_out_t o;
        o.sys_clk_en = 1'b1;
        o.dbg_clk_en = 1'b1;
        o.reg_stby   = 1'b0;
        o.io_hiz     = 1'b0;
        o.io_hold    = 1'b0;
        o.exit_rst   = 1'b0;
        o.mode       = MODE_RUN;
        case (s)
            ST_LIGHT: begin
                o.sys_clk_en = dbg_en;
                o.dbg_clk_en = dbg_en;
                o.reg_stby   = !dbg_en;
                o.io_hold    = 1'b1;
                o.mode       = MODE_LIGHT;
            end
            ST_DEEP: begin
                o.sys_clk_en = 1'b0;
                o.dbg_clk_en = 1'b0;
                o.reg_stby   = 1'b1;
                o.io_hiz     = 1'b1;
                o.mode       = MODE_DEEP;
            end
            ST_WAKE_L: begin
                o.io_hold = 1'b1;
                o.mode    = MODE_LIGHT;
            end
            ST_WAKE_D: begin
                o.io_hiz   = 1'b1;
                o.exit_rst = 1'b1;
                o.mode     = MODE_DEEP;
            end
            ST_DEBUG: o.mode = MODE_DEBUG;
            default: ;
        endcase
        return o;
    endfunction

    function automatic logic is_stopped(input mode_e m);
        return (m == MODE_LIGHT) || (m == MODE_DEEP);
    endfunction

endpackage

// File: rtl/stopctl_dbg.sv
module stopctl_dbg (
    input  logic       clk,
    input  logic       rst,
    input  logic       live,
    input  logic       stopped,
    input  logic       wr_ctl,
    input  logic       wr_val,
    input  logic       rd_stat,
    input  logic       mem_cmd,
    output logic       en_q,
    output logic       rd_valid_q,
    output logic [1:0] rd_data_q,
    output logic       mem_valid_q,
    output logic       mem_err_q,
    output logic       mem_do_q
);
    logic wr_ok, rd_ok, mem_ok;

    assign wr_ok  = live && wr_ctl;
    assign rd_ok  = live && rd_stat;
    assign mem_ok = live && mem_cmd;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q        <= 1'b0;
            rd_valid_q  <= 1'b0;
            rd_data_q   <= 2'b00;
            mem_valid_q <= 1'b0;
            mem_err_q   <= 1'b0;
            mem_do_q    <= 1'b0;
        end else begin
            if (wr_ok) en_q <= wr_val;
            rd_valid_q  <= rd_ok;
            rd_data_q   <= rd_ok ? {stopped, en_q} : 2'b00;
            mem_valid_q <= mem_ok;
            mem_err_q   <= mem_ok && stopped;
            mem_do_q    <= mem_ok && !stopped;
        end
    end

    // R11: the enable bit cannot move while the debug clock is gated
    assert_en_frozen_R11: assert property (@(posedge clk) disable iff (rst)
        !live |=> $stable(en_q));

    // R4: a response is either refused or performed, never both
    assert_mem_excl_R4: assert property (@(posedge clk) disable iff (rst)
        mem_valid_q |-> (mem_err_q != mem_do_q));

endmodule

// File: rtl/stopctl_wake.sv
module stopctl_wake #(
    parameter int IRQ_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IRQ_W-1:0] irq,
    input  logic             tick,
    input  logic             tick_ack,
    input  logic             in_deep,
    output logic             wake,
    output logic             flag_q
);
    localparam int LAST = IRQ_W - 1;

    logic [LAST:0] any_chain;

    generate
        for (genvar i = 0; i <= LAST; i++) begin : g_or
            if (i == 0) begin : g_first
                assign any_chain[i] = irq[i];
            end else begin : g_next
                assign any_chain[i] = any_chain[i-1] | irq[i];
            end
        end
    endgenerate

    assign wake = any_chain[LAST] | tick;

    always_ff @(posedge clk) begin
        if (rst) flag_q <= 1'b0;
        else     flag_q <= (tick && !in_deep) || (flag_q && !tick_ack);
    end

    // R7: no flag can appear from deep stop
    assert_no_flag_deep_R7: assert property (@(posedge clk) disable iff (rst)
        (in_deep && !flag_q) |=> !flag_q);

endmodule

// File: rtl/stopctl_fsm.sv
module stopctl_fsm
    import stopctl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   stop_exec,
    input  logic   stop_deep,
    input  logic   dbg_en,
    input  logic   halt_ok,
    input  logic   resume_ok,
    input  logic   wake,
    output state_e state_q
);
    state_e state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_RUN: begin
                if (halt_ok)        state_d = ST_DEBUG;
                else if (stop_exec) state_d = (stop_deep && !dbg_en) ? ST_DEEP : ST_LIGHT;
            end
            ST_LIGHT: begin
                if (halt_ok)   state_d = ST_DEBUG;
                else if (wake) state_d = ST_WAKE_L;
            end
            ST_DEEP:   if (wake) state_d = ST_WAKE_D;
            ST_WAKE_L: state_d = ST_RUN;
            ST_WAKE_D: state_d = ST_RUN;
            ST_DEBUG:  if (resume_ok) state_d = ST_RUN;
            default:   state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_RUN;
        else     state_q <= state_d;
    end

    // R3: deep stop is never occupied while debug is enabled
    assert_deep_no_dbg_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DEEP) |-> !dbg_en);

    // R8: the light-stop exit lasts exactly one cycle
    assert_light_exit_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAKE_L) |=> (state_q == ST_RUN));

    // R10: resume from debug returns to run
    assert_resume_R10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DEBUG && resume_ok) |=> (state_q == ST_RUN));

endmodule

// File: rtl/stop_mode_ctrl.sv
module stop_mode_ctrl
    import stopctl_pkg::*;
#(
    parameter int IRQ_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stop_exec,
    input  logic             stop_deep,
    input  logic [IRQ_W-1:0] irq,
    input  logic             tmr_tick,
    input  logic             tmr_ack,
    input  logic             dbg_wr_ctl,
    input  logic             dbg_wr_val,
    input  logic             dbg_rd_stat,
    input  logic             dbg_mem_cmd,
    input  logic             dbg_halt,
    input  logic             dbg_resume,
    output logic [1:0]       mode,
    output logic             sys_clk_en,
    output logic             dbg_clk_en,
    output logic             reg_stby,
    output logic             io_hiz,
    output logic             io_hold,
    output logic             exit_rst,
    output logic             tmr_flag,
    output logic             dbg_rd_valid,
    output logic [1:0]       dbg_rd_data,
    output logic             dbg_mem_valid,
    output logic             dbg_mem_err,
    output logic             dbg_mem_do
);
    state_e   state_q;
    ctl_out_t outs;
    logic     dbg_en, live, stopped, in_deep, wake;

    assign outs    = decode_state(state_q, dbg_en);
    assign live    = outs.dbg_clk_en;
    assign stopped = is_stopped(outs.mode);
    assign in_deep = (outs.mode == MODE_DEEP);

    stopctl_dbg u_dbg (
        .clk(clk), .rst(rst), .live(live), .stopped(stopped),
        .wr_ctl(dbg_wr_ctl), .wr_val(dbg_wr_val), .rd_stat(dbg_rd_stat),
        .mem_cmd(dbg_mem_cmd), .en_q(dbg_en), .rd_valid_q(dbg_rd_valid),
        .rd_data_q(dbg_rd_data), .mem_valid_q(dbg_mem_valid),
        .mem_err_q(dbg_mem_err), .mem_do_q(dbg_mem_do)
    );

    stopctl_wake #(.IRQ_W(IRQ_W)) u_wake (
        .clk(clk), .rst(rst), .irq(irq), .tick(tmr_tick), .tick_ack(tmr_ack),
        .in_deep(in_deep), .wake(wake), .flag_q(tmr_flag)
    );

    stopctl_fsm u_fsm (
        .clk(clk), .rst(rst), .stop_exec(stop_exec), .stop_deep(stop_deep),
        .dbg_en(dbg_en), .halt_ok(live && dbg_en && dbg_halt),
        .resume_ok(live && dbg_resume), .wake(wake), .state_q(state_q)
    );

    assign mode       = outs.mode;
    assign sys_clk_en = outs.sys_clk_en;
    assign dbg_clk_en = outs.dbg_clk_en;
    assign reg_stby   = outs.reg_stby;
    assign io_hiz     = outs.io_hiz;
    assign io_hold    = outs.io_hold;
    assign exit_rst   = outs.exit_rst;

    // R2: pins float only in deep stop or its exit
    assert_hiz_deep_R2: assert property (@(posedge clk) disable iff (rst)
        io_hiz |-> (mode == MODE_DEEP));

    // R3: regulator standby never requested with debug enabled
    assert_stby_dbg_R3: assert property (@(posedge clk) disable iff (rst)
        reg_stby |-> !dbg_en);

    // R9: exit pulse from deep stop is followed by run
    assert_deep_exit_R9: assert property (@(posedge clk) disable iff (rst)
        exit_rst |=> (mode == MODE_RUN && !exit_rst));

endmodule

// File: tb/stop_mode_ctrl_bench.sv
`timescale 1ns/1ps
module stop_mode_ctrl_bench;
    localparam int IRQ_W = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stop_exec = 0, stop_deep = 0, tmr_tick = 0, tmr_ack = 0;
    logic [IRQ_W-1:0] irq = '0;
    logic dbg_wr_ctl = 0, dbg_wr_val = 0, dbg_rd_stat = 0, dbg_mem_cmd = 0;
    logic dbg_halt = 0, dbg_resume = 0;
    logic [1:0] mode, dbg_rd_data;
    logic sys_clk_en, dbg_clk_en, reg_stby, io_hiz, io_hold, exit_rst, tmr_flag;
    logic dbg_rd_valid, dbg_mem_valid, dbg_mem_err, dbg_mem_do;
    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    stop_mode_ctrl #(.IRQ_W(IRQ_W)) u_stop_mode_ctrl (.*);

    // expected {sys,dbg,stby,hiz,hold,exit}
    localparam logic [5:0] O_RUN = 6'b110000, O_DEEP = 6'b001100, O_LT0 = 6'b001010,
                           O_LT1 = 6'b110010, O_WKD = 6'b110101, O_WKL = 6'b110010;

    function automatic logic [5:0] outv();
        return {sys_clk_en, dbg_clk_en, reg_stby, io_hiz, io_hold, exit_rst};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(); @(posedge clk); #1; endtask
    task automatic do_reset(); rst = 1; step(); step(); rst = 0; endtask
    task automatic p_stop(input logic d); stop_exec = 1; stop_deep = d; step(); stop_exec = 0; stop_deep = 0; endtask
    task automatic p_wr(input logic v); dbg_wr_ctl = 1; dbg_wr_val = v; step(); dbg_wr_ctl = 0; dbg_wr_val = 0; endtask
    task automatic p_rd(); dbg_rd_stat = 1; step(); dbg_rd_stat = 0; endtask
    task automatic p_mem(); dbg_mem_cmd = 1; step(); dbg_mem_cmd = 0; endtask
    task automatic p_halt(); dbg_halt = 1; step(); dbg_halt = 0; endtask
    task automatic p_resume(); dbg_resume = 1; step(); dbg_resume = 0; endtask
    task automatic p_irq(input int i); irq[i] = 1; step(); irq = '0; endtask
    task automatic p_tick(); tmr_tick = 1; step(); tmr_tick = 0; endtask
    task automatic p_ack(); tmr_ack = 1; step(); tmr_ack = 0; endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1 reset state
        do_reset();
        chk("R1 mode", mode, 0);
        chk("R1 outs", outv(), O_RUN);
        chk("R1 flag", tmr_flag, 0);
        p_rd();
        chk("R1 rd", {dbg_rd_valid, dbg_rd_data}, 3'b100);

        // R2/R3/R8/R9 sweep over enable and depth
        for (int e = 0; e < 2; e++) begin
            for (int d = 0; d < 2; d++) begin
                do_reset();
                if (e == 1) p_wr(1);
                p_rd();
                chk("R6 readback", {dbg_rd_valid, dbg_rd_data}, {2'b10, e[0]});
                p_stop(d[0]);
                if (d == 1 && e == 0) begin
                    chk("R2 deep mode", mode, 2);
                    chk("R2 deep outs", outv(), O_DEEP);
                end else begin
                    chk(e == 1 ? "R3 mode" : "R2 light mode", mode, 1);
                    chk(e == 1 ? "R3 outs" : "R2 light outs", outv(), e == 1 ? O_LT1 : O_LT0);
                end
                p_irq((e * 2 + d) % IRQ_W);
                if (d == 1 && e == 0) begin
                    chk("R9 exit mode", mode, 2);
                    chk("R9 exit outs", outv(), O_WKD);
                end else begin
                    chk("R8 exit mode", mode, 1);
                    chk("R8 exit outs", outv(), O_WKL);
                end
                step();
                chk("R8 R9 run", {mode, outv()}, {2'd0, O_RUN});
            end
        end

        // R8/R9 every interrupt line from both depths
        for (int i = 0; i < IRQ_W; i++) begin
            for (int d = 0; d < 2; d++) begin
                do_reset();
                p_stop(d[0]);
                p_irq(i);
                chk(d == 1 ? "R9 line" : "R8 line", mode, d == 1 ? 2 : 1);
                chk("R8 R9 sysclk", sys_clk_en, 1);
                step();
                chk("R8 R9 line run", mode, 0);
            end
        end

        // R7 timer flag
        do_reset();
        p_stop(1);
        p_tick();
        chk("R7 deep tick wakes", {mode, exit_rst}, 3'b101);
        chk("R7 deep no flag", tmr_flag, 0);
        step();
        chk("R7 deep no flag later", {mode, tmr_flag}, 3'b000);
        p_tick();
        chk("R7 run flag", tmr_flag, 1);
        p_ack();
        chk("R7 ack clears", tmr_flag, 0);
        tmr_tick = 1; tmr_ack = 1; step(); tmr_tick = 0; tmr_ack = 0;
        chk("R7 tick beats ack", tmr_flag, 1);
        p_ack();
        p_stop(0);
        p_tick();
        chk("R7 light flag", {mode, tmr_flag}, 3'b011);
        step();
        chk("R8 tick exit run", mode, 0);

        // R4 memory command in each mode
        do_reset();
        p_mem();
        chk("R4 run mem", {dbg_mem_valid, dbg_mem_err, dbg_mem_do}, 3'b101);
        step();
        chk("R4 one shot", dbg_mem_valid, 0);
        p_wr(1);
        p_stop(1);
        chk("R3 deep downgraded", mode, 1);
        p_mem();
        chk("R4 stopped mem", {dbg_mem_valid, dbg_mem_err, dbg_mem_do}, 3'b110);
        p_rd();
        chk("R6 stopped status", {dbg_rd_valid, dbg_rd_data}, 3'b111);

        // R5 halt from light stop, R10 debug behaviour
        p_halt();
        chk("R5 light halt", {mode, outv()}, {2'd3, O_RUN});
        p_stop(1);
        chk("R10 stop ignored", mode, 3);
        p_irq(0);
        chk("R10 irq ignored", mode, 3);
        p_mem();
        chk("R10 mem in debug", {dbg_mem_valid, dbg_mem_err, dbg_mem_do}, 3'b101);
        p_resume();
        chk("R10 resume", mode, 0);
        p_halt();
        chk("R5 run halt", mode, 3);
        p_resume();

        // R5 halt ignored without enable
        do_reset();
        p_halt();
        chk("R5 halt ignored run", mode, 0);
        p_stop(0);
        p_halt();
        chk("R5 halt ignored light", mode, 1);

        // R11 commands ignored with debug clock off
        p_wr(1);
        p_rd();
        chk("R11 no rd resp", dbg_rd_valid, 0);
        p_mem();
        chk("R11 no mem resp", dbg_mem_valid, 0);
        p_irq(1);
        step();
        p_rd();
        chk("R11 enable unchanged", {dbg_rd_valid, dbg_rd_data}, 3'b100);

        // R12 reset from deep stop, and with enable set
        p_stop(1);
        chk("R12 in deep", mode, 2);
        do_reset();
        chk("R12 reset deep", {mode, outv()}, {2'd0, O_RUN});
        p_wr(1);
        do_reset();
        p_rd();
        chk("R12 enable cleared", {dbg_rd_valid, dbg_rd_data}, 3'b100);

        finish_run();
    end
endmodule